// File: doc/BRIEF.md
# Coherence Transaction Ack Tracker

This block keeps the state of one outstanding directory transaction for a single cache line. A request is allocated with its line address, a request kind, a flag telling whether sharer tracking is enabled, and for DMA writes a byte offset, byte length and write data. From then on the tracker counts down the probe responses it still expects. It also notes whether any responder reported a shared copy or an owned copy, and it captures line data from the memory path or from a cache.

When the count reaches zero the tracker raises one completion pulse. The pulse carries the line address and a three-way outcome class. For a DMA write it also delivers the captured line with the DMA bytes merged in, ready to be written back. Memory data returned for the line is forwarded once, with the response type and acknowledgment count recorded at allocation. The slot stays occupied until an explicit deallocate.

Top module: `txn_ack_tracker`

## Requirements
- R1: After reset, busy_o, pend_o, err_o, dirty_o, evt_valid_o, wb_valid_o and mem_rsp_valid_o are all 0.
- R2: An allocate request while idle sets busy_o, loads pend_o with NUM_CACHES, and clears the line, dirty_o and both copy flags. mem_rsp_excl_o becomes 0 for kind 0 (read shared) and 1 for kinds 1 (read exclusive), 2 (DMA read) and 3 (DMA write). mem_rsp_acks_o becomes NUM_CACHES when alloc_filt_i was 1, and 1 otherwise. An allocate request while busy has no effect.
- R3: Each accepted response lowers pend_o by exactly one, whatever its kind and whether or not it carries data.
- R4: Response kind 1 (shared ack) sets the sharer flag. Kind 2 (shared data) sets both the sharer and owner flags. Kinds 0 (ack), 3 (data) and 4 (exclusive data) leave the flags unchanged. Flags hold until the next allocation.
- R5: In the cycle after pend_o reaches zero, evt_valid_o pulses for exactly one cycle with evt_addr_o equal to the allocated address. evt_kind_o is 2 if the owner and sharer flags are set, 1 if only the sharer flag is set, and 0 otherwise.
- R6: Response kinds 2, 3 and 4 overwrite the captured line with rsp_data_i and set dirty_o. Memory data is captured only while dirty_o is clear. When cache data and memory data arrive in the same cycle, the cache data is kept.
- R7: One cycle after mem_valid_i while busy, mem_rsp_valid_o pulses with mem_rsp_data_o equal to that memory data. The recorded mem_rsp_excl_o and mem_rsp_acks_o are presented with it.
- R8: A count override while busy works by code. Code 0 sets pend_o to 1 and code 1 sets it to NUM_CACHES. Code 2 sets it to 0 only when alloc_filt_i was 1; otherwise it has no effect. An override takes precedence over a response arriving in the same cycle, although that response still updates the flags and the line.
- R9: When a DMA write (kind 3) completes, wb_valid_o pulses together with evt_valid_o. wb_data_o is the captured line with byte i (bits 8i+7..8i) replaced by the DMA data byte i for every i with off <= i < off+len. Other kinds never pulse wb_valid_o.
- R10: A response arriving while idle, or while pend_o is already 0, sets err_o, which stays set until reset. Such a response changes neither the count, the flags nor the line.
- R11: Deallocate clears busy_o and pend_o, and the next allocate is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| alloc_valid_i | input | 1 | Allocate request |
| alloc_addr_i | input | ADDR_W | Line address |
| alloc_kind_i | input | 2 | Request kind (0 read shared, 1 read exclusive, 2 DMA read, 3 DMA write) |
| alloc_filt_i | input | 1 | Sharer tracking enabled for this transaction |
| alloc_off_i | input | OFF_W | DMA byte offset within the line |
| alloc_len_i | input | LEN_W | DMA byte count |
| alloc_data_i | input | 8*LINE_BYTES | DMA write data, byte-aligned to the line |
| dealloc_i | input | 1 | Release the slot |
| pend_set_valid_i | input | 1 | Override pending count |
| pend_set_sel_i | input | 2 | Override code (0 one, 1 all, 2 zero if tracking enabled) |
| rsp_valid_i | input | 1 | Probe response valid |
| rsp_kind_i | input | 3 | Response kind (0 ack, 1 shared ack, 2 shared data, 3 data, 4 exclusive data) |
| rsp_data_i | input | 8*LINE_BYTES | Response data |
| mem_valid_i | input | 1 | Memory data valid |
| mem_data_i | input | 8*LINE_BYTES | Memory data |
| busy_o | output | 1 | Slot allocated |
| pend_o | output | CNT_W | Responses still expected |
| line_o | output | 8*LINE_BYTES | Captured line |
| dirty_o | output | 1 | Line came from a cache |
| err_o | output | 1 | Sticky protocol error |
| evt_valid_o | output | 1 | Completion pulse |
| evt_addr_o | output | ADDR_W | Completion address |
| evt_kind_o | output | 2 | Outcome (0 no sharers, 1 shared, 2 owner exists) |
| wb_valid_o | output | 1 | Merged write-back valid |
| wb_data_o | output | 8*LINE_BYTES | Merged write-back line |
| mem_rsp_valid_o | output | 1 | Forwarded memory data valid |
| mem_rsp_data_o | output | 8*LINE_BYTES | Forwarded memory data |
| mem_rsp_excl_o | output | 1 | Recorded response type is exclusive |
| mem_rsp_acks_o | output | CNT_W | Acknowledgment count for the requestor |

## Verification
Two collisions matter here. The first is cache data and memory data landing in the same cycle. A sweep of every four-response pattern presents memory data together with the second response, and the final line is compared with a bench model in which cache data always wins and memory data counts only while the line is clean. The second collision is a count override arriving together with a response. It is provoked directly, and the check requires the count to follow the override while the response's data and flags are still taken up.

// File: rtl/txn_trk_pkg.sv
package txn_trk_pkg;

    typedef enum logic [1:0] {
        REQ_RD_SHARED = 2'd0,
        REQ_RD_EXCL   = 2'd1,
        REQ_DMA_RD    = 2'd2,
        REQ_DMA_WR    = 2'd3
    } req_kind_e;

    localparam logic [2:0] RSP_ACK     = 3'd0;
    localparam logic [2:0] RSP_ACK_SH  = 3'd1;
    localparam logic [2:0] RSP_DATA_SH = 3'd2;
    localparam logic [2:0] RSP_DATA    = 3'd3;
    localparam logic [2:0] RSP_DATA_EX = 3'd4;

    localparam logic [1:0] PSET_ONE  = 2'd0;
    localparam logic [1:0] PSET_ALL  = 2'd1;
    localparam logic [1:0] PSET_ZERO = 2'd2;

    localparam logic [1:0] EVT_NO_SHARERS = 2'd0;
    localparam logic [1:0] EVT_SHARED     = 2'd1;
    localparam logic [1:0] EVT_OWNED      = 2'd2;

    function automatic logic rsp_carries_data(logic [2:0] k);
        return (k == RSP_DATA_SH) || (k == RSP_DATA) || (k == RSP_DATA_EX);
    endfunction

    function automatic logic [1:0] classify(logic sharer, logic owner);
        if (sharer && owner) return EVT_OWNED;
        if (sharer)          return EVT_SHARED;
        return EVT_NO_SHARERS;
    endfunction

endpackage

// File: rtl/trk_pend_next.sv
module trk_pend_next
    import txn_trk_pkg::*;
#(
    parameter int NUM_CACHES = 4,
    parameter int CNT_W      = 3
) (
    input  logic [CNT_W-1:0] pend_q,
    input  logic             busy_q,
    input  logic             filt_q,
    input  logic             dealloc,
    input  logic             alloc_take,
    input  logic             set_valid,
    input  logic [1:0]       set_sel,
    input  logic             rsp_take,
    output logic [CNT_W-1:0] pend_d,
    output logic             zero_hit
);
    localparam logic [CNT_W-1:0] ALL_CNT = CNT_W'(NUM_CACHES);

    always_comb begin
        pend_d = pend_q;
        if (dealloc) begin
            pend_d = '0;
        end else if (alloc_take) begin
            pend_d = ALL_CNT;
        end else if (set_valid && busy_q) begin
            case (set_sel)
                PSET_ONE:  pend_d = CNT_W'(1);
                PSET_ALL:  pend_d = ALL_CNT;
                PSET_ZERO: pend_d = filt_q ? '0 : pend_q;
                default:   pend_d = pend_q;
            endcase
        end else if (rsp_take) begin
            pend_d = pend_q - CNT_W'(1);
        end
        zero_hit = busy_q && !dealloc && (pend_q != '0) && (pend_d == '0);
    end
endmodule

// File: rtl/trk_line_next.sv
module trk_line_next
    import txn_trk_pkg::*;
#(
    parameter int LINE_W = 64
) (
    input  logic              alloc_take,
    input  logic              rsp_take,
    input  logic [2:0]        rsp_kind,
    input  logic [LINE_W-1:0] rsp_data,
    input  logic              mem_take,
    input  logic [LINE_W-1:0] mem_data,
    input  logic [LINE_W-1:0] line_q,
    input  logic              dirty_q,
    input  logic              sharer_q,
    input  logic              owner_q,
    output logic [LINE_W-1:0] line_d,
    output logic              dirty_d,
    output logic              sharer_d,
    output logic              owner_d
);
    always_comb begin
        line_d   = line_q;
        dirty_d  = dirty_q;
        sharer_d = sharer_q;
        owner_d  = owner_q;
        if (alloc_take) begin
            line_d   = '0;
            dirty_d  = 1'b0;
            sharer_d = 1'b0;
            owner_d  = 1'b0;
        end else begin
            if (rsp_take && rsp_carries_data(rsp_kind)) begin
                line_d  = rsp_data;
                dirty_d = 1'b1;
            end else if (mem_take && !dirty_q) begin
                line_d = mem_data;
            end
            if (rsp_take && (rsp_kind == RSP_ACK_SH || rsp_kind == RSP_DATA_SH)) begin
                sharer_d = 1'b1;
            end
            if (rsp_take && rsp_kind == RSP_DATA_SH) begin
                owner_d = 1'b1;
            end
        end
    end
endmodule

// File: rtl/trk_byte_merge.sv
module trk_byte_merge #(
    parameter int LINE_BYTES = 8,
    parameter int OFF_W      = 3,
    parameter int LEN_W      = 4
) (
    input  logic [8*LINE_BYTES-1:0] base,
    input  logic [8*LINE_BYTES-1:0] patch,
    input  logic [OFF_W-1:0]        off,
    input  logic [LEN_W-1:0]        len,
    output logic [8*LINE_BYTES-1:0] merged
);
    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] lo;
    logic [SUM_W-1:0] hi;
    assign lo = SUM_W'(off);
    assign hi = SUM_W'(off) + SUM_W'(len);

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        logic take;
        assign take = (SUM_W'(b) >= lo) && (SUM_W'(b) < hi);
        assign merged[8*b +: 8] = take ? patch[8*b +: 8] : base[8*b +: 8];
    end
endmodule

// File: rtl/txn_ack_tracker.sv
module txn_ack_tracker
    import txn_trk_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 8,
    parameter int NUM_CACHES = 4,
    localparam int LINE_W    = 8 * LINE_BYTES,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LEN_W     = $clog2(LINE_BYTES + 1),
    localparam int CNT_W     = $clog2(NUM_CACHES + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              alloc_valid_i,
    input  logic [ADDR_W-1:0] alloc_addr_i,
    input  logic [1:0]        alloc_kind_i,
    input  logic              alloc_filt_i,
    input  logic [OFF_W-1:0]  alloc_off_i,
    input  logic [LEN_W-1:0]  alloc_len_i,
    input  logic [LINE_W-1:0] alloc_data_i,
    input  logic              dealloc_i,
    input  logic              pend_set_valid_i,
    input  logic [1:0]        pend_set_sel_i,
    input  logic              rsp_valid_i,
    input  logic [2:0]        rsp_kind_i,
    input  logic [LINE_W-1:0] rsp_data_i,
    input  logic              mem_valid_i,
    input  logic [LINE_W-1:0] mem_data_i,
    output logic              busy_o,
    output logic [CNT_W-1:0]  pend_o,
    output logic [LINE_W-1:0] line_o,
    output logic              dirty_o,
    output logic              err_o,
    output logic              evt_valid_o,
    output logic [ADDR_W-1:0] evt_addr_o,
    output logic [1:0]        evt_kind_o,
    output logic              wb_valid_o,
    output logic [LINE_W-1:0] wb_data_o,
    output logic              mem_rsp_valid_o,
    output logic [LINE_W-1:0] mem_rsp_data_o,
    output logic              mem_rsp_excl_o,
    output logic [CNT_W-1:0]  mem_rsp_acks_o
);

    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] addr;
        req_kind_e         kind;
        logic              filt;
        logic [OFF_W-1:0]  off;
        logic [LEN_W-1:0]  len;
        logic [LINE_W-1:0] dma;
        logic [CNT_W-1:0]  pend;
        logic [LINE_W-1:0] line;
        logic              dirty;
        logic              sharer;
        logic              owner;
        logic              err;
        logic              evt_valid;
        logic [1:0]        evt_kind;
        logic              wb_valid;
        logic [LINE_W-1:0] wb_data;
        logic              mem_rsp_valid;
        logic [LINE_W-1:0] mem_rsp_data;
    } state_t;

    state_t st_d, st_q;

    logic              alloc_take, rsp_take, mem_take, zero_hit;
    logic [CNT_W-1:0]  pend_nx;
    logic [LINE_W-1:0] line_nx, merged_nx;
    logic              dirty_nx, sharer_nx, owner_nx;

    assign alloc_take = alloc_valid_i && !st_q.busy && !dealloc_i;
    assign rsp_take   = rsp_valid_i && st_q.busy && (st_q.pend != '0);
    assign mem_take   = mem_valid_i && st_q.busy;

    trk_pend_next #(.NUM_CACHES(NUM_CACHES), .CNT_W(CNT_W)) u_pend (
        .pend_q    (st_q.pend),
        .busy_q    (st_q.busy),
        .filt_q    (st_q.filt),
        .dealloc   (dealloc_i),
        .alloc_take(alloc_take),
        .set_valid (pend_set_valid_i),
        .set_sel   (pend_set_sel_i),
        .rsp_take  (rsp_take),
        .pend_d    (pend_nx),
        .zero_hit  (zero_hit)
    );

    trk_line_next #(.LINE_W(LINE_W)) u_line (
        .alloc_take(alloc_take),
        .rsp_take  (rsp_take),
        .rsp_kind  (rsp_kind_i),
        .rsp_data  (rsp_data_i),
        .mem_take  (mem_take),
        .mem_data  (mem_data_i),
        .line_q    (st_q.line),
        .dirty_q   (st_q.dirty),
        .sharer_q  (st_q.sharer),
        .owner_q   (st_q.owner),
        .line_d    (line_nx),
        .dirty_d   (dirty_nx),
        .sharer_d  (sharer_nx),
        .owner_d   (owner_nx)
    );

    trk_byte_merge #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_merge (
        .base  (line_nx),
        .patch (st_q.dma),
        .off   (st_q.off),
        .len   (st_q.len),
        .merged(merged_nx)
    );

    always_comb begin
        st_d = st_q;
        if (dealloc_i) begin
            st_d.busy = 1'b0;
        end else if (alloc_take) begin
            st_d.busy = 1'b1;
            st_d.addr = alloc_addr_i;
            st_d.kind = req_kind_e'(alloc_kind_i);
            st_d.filt = alloc_filt_i;
            st_d.off  = alloc_off_i;
            st_d.len  = alloc_len_i;
            st_d.dma  = alloc_data_i;
        end
        st_d.pend          = pend_nx;
        st_d.line          = line_nx;
        st_d.dirty         = dirty_nx;
        st_d.sharer        = sharer_nx;
        st_d.owner         = owner_nx;
        st_d.err           = st_q.err || (rsp_valid_i && !rsp_take);
        st_d.evt_valid     = zero_hit;
        st_d.evt_kind      = zero_hit ? classify(sharer_nx, owner_nx) : st_q.evt_kind;
        st_d.wb_valid      = zero_hit && (st_q.kind == REQ_DMA_WR);
        st_d.wb_data       = zero_hit ? merged_nx : st_q.wb_data;
        st_d.mem_rsp_valid = mem_take;
        st_d.mem_rsp_data  = mem_take ? mem_data_i : st_q.mem_rsp_data;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign busy_o          = st_q.busy;
    assign pend_o          = st_q.pend;
    assign line_o          = st_q.line;
    assign dirty_o         = st_q.dirty;
    assign err_o           = st_q.err;
    assign evt_valid_o     = st_q.evt_valid;
    assign evt_addr_o      = st_q.addr;
    assign evt_kind_o      = st_q.evt_kind;
    assign wb_valid_o      = st_q.wb_valid;
    assign wb_data_o       = st_q.wb_data;
    assign mem_rsp_valid_o = st_q.mem_rsp_valid;
    assign mem_rsp_data_o  = st_q.mem_rsp_data;
    assign mem_rsp_excl_o  = (st_q.kind != REQ_RD_SHARED);
    assign mem_rsp_acks_o  = st_q.filt ? CNT_W'(NUM_CACHES) : CNT_W'(1);

    AST_PEND_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_o <= CNT_W'(NUM_CACHES)); // R2
    AST_IDLE_ALLOC_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && alloc_valid_i && !dealloc_i) |=> (busy_o && pend_o == CNT_W'(NUM_CACHES))); // R2
    AST_DEC_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && rsp_valid_i && pend_o != '0 && !pend_set_valid_i && !dealloc_i)
        |=> (pend_o == $past(pend_o) - CNT_W'(1))); // R3
    AST_EVT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_valid_o |=> !evt_valid_o); // R5
    AST_DIRTY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && dirty_o && !dealloc_i) |=> dirty_o); // R6
    AST_MEM_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && mem_valid_i) |=> mem_rsp_valid_o); // R7
    AST_WB_WITH_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wb_valid_o |-> evt_valid_o); // R9
    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> err_o); // R10

endmodule

// File: tb/txn_ack_tracker_bench.sv
`timescale 1ns/1ps
module txn_ack_tracker_bench;
    localparam int NB = 8;
    localparam int NC = 4;
    localparam int LW = 8 * NB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          alloc_valid = 0, alloc_filt = 0, dealloc = 0;
    logic [15:0]   alloc_addr = 0;
    logic [1:0]    alloc_kind = 0;
    logic [2:0]    alloc_off = 0;
    logic [3:0]    alloc_len = 0;
    logic [LW-1:0] alloc_data = 0;
    logic          pset_valid = 0;
    logic [1:0]    pset_sel = 0;
    logic          rsp_valid = 0;
    logic [2:0]    rsp_kind = 0;
    logic [LW-1:0] rsp_data = 0;
    logic          mem_valid = 0;
    logic [LW-1:0] mem_data = 0;

    logic          busy, dirty, err, evt_valid, wb_valid, mrsp_valid, mrsp_excl;
    logic [2:0]    pend, mrsp_acks;
    logic [LW-1:0] line, wb_data, mrsp_data;
    logic [15:0]   evt_addr;
    logic [1:0]    evt_kind;

    int checks = 0;
    int fails  = 0;

    txn_ack_tracker u_txn_ack_tracker (
        .clk_i(clk), .rst_ni(rst_n),
        .alloc_valid_i(alloc_valid), .alloc_addr_i(alloc_addr), .alloc_kind_i(alloc_kind),
        .alloc_filt_i(alloc_filt), .alloc_off_i(alloc_off), .alloc_len_i(alloc_len),
        .alloc_data_i(alloc_data), .dealloc_i(dealloc),
        .pend_set_valid_i(pset_valid), .pend_set_sel_i(pset_sel),
        .rsp_valid_i(rsp_valid), .rsp_kind_i(rsp_kind), .rsp_data_i(rsp_data),
        .mem_valid_i(mem_valid), .mem_data_i(mem_data),
        .busy_o(busy), .pend_o(pend), .line_o(line), .dirty_o(dirty), .err_o(err),
        .evt_valid_o(evt_valid), .evt_addr_o(evt_addr), .evt_kind_o(evt_kind),
        .wb_valid_o(wb_valid), .wb_data_o(wb_data),
        .mem_rsp_valid_o(mrsp_valid), .mem_rsp_data_o(mrsp_data),
        .mem_rsp_excl_o(mrsp_excl), .mem_rsp_acks_o(mrsp_acks)
    );

    task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step(); step(); rst_n = 1'b1; step();
    endtask

    function automatic logic [LW-1:0] pattern(input int seed);
        logic [LW-1:0] v;
        for (int b = 0; b < NB; b++) v[8*b +: 8] = 8'(seed + b * 29 + 3);
        return v;
    endfunction

    function automatic logic [LW-1:0] merge(input logic [LW-1:0] base, input logic [LW-1:0] dma,
                                            input int off, input int len);
        logic [LW-1:0] v = base;
        for (int b = 0; b < NB; b++) if (b >= off && b < off + len) v[8*b +: 8] = dma[8*b +: 8];
        return v;
    endfunction

    task automatic alloc(input logic [15:0] a, input logic [1:0] k, input logic f,
                         input int off, input int len, input logic [LW-1:0] d);
        alloc_valid = 1; alloc_addr = a; alloc_kind = k; alloc_filt = f;
        alloc_off = 3'(off); alloc_len = 4'(len); alloc_data = d;
        step(); alloc_valid = 0;
    endtask

    task automatic respond(input logic [2:0] k, input logic [LW-1:0] d);
        rsp_valid = 1; rsp_kind = k; rsp_data = d; step(); rsp_valid = 0;
    endtask

    task automatic release_slot();
        dealloc = 1; step(); dealloc = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        do_reset();
        // R1 reset state
        chk("R1 busy", LW'(busy), 0); chk("R1 pend", LW'(pend), 0);
        chk("R1 err", LW'(err), 0); chk("R1 dirty", LW'(dirty), 0);
        chk("R1 evt", LW'(evt_valid), 0); chk("R1 wb", LW'(wb_valid), 0);
        chk("R1 mrsp", LW'(mrsp_valid), 0);

        // Sweep of all four-response patterns, memory data alongside the second response
        for (int p = 0; p < 256; p++) begin
            logic [1:0] kind = 2'((p / 3) % 4);
            logic filt = 1'((p / 7) % 2);
            int off = p % NB;
            int len = (p / 5) % (NB + 1);
            logic [15:0] a = 16'(p * 37 + 5);
            logic [LW-1:0] dma = pattern(p + 100);
            logic [LW-1:0] md = pattern(p + 200);
            logic [LW-1:0] exp_line = '0;
            logic exp_dirty = 0, sh = 0, ow = 0;
            logic [1:0] exp_evt;
            alloc(a, kind, filt, off, len, dma);
            chk("R2 busy", LW'(busy), 1); chk("R2 pend", LW'(pend), NC);
            chk("R2 excl", LW'(mrsp_excl), LW'(kind != 0));
            chk("R2 acks", LW'(mrsp_acks), filt ? NC : 1);
            for (int i = 0; i < 4; i++) begin
                int code = (p >> (2 * i)) & 3;
                logic [2:0] rk = (code == 0) ? 3'd0 : (code == 1) ? 3'd1 :
                                 (code == 2) ? 3'd2 : ((i % 2) ? 3'd3 : 3'd4);
                logic [LW-1:0] rd = pattern(p * 3 + i * 17);
                if (rk >= 2) begin exp_line = rd; exp_dirty = 1; end
                else if (i == 1 && !exp_dirty) exp_line = md;
                if (rk == 1 || rk == 2) sh = 1;
                if (rk == 2) ow = 1;
                if (i == 1) begin mem_valid = 1; mem_data = md; end
                respond(rk, rd);
                mem_valid = 0;
                chk("R3 pend", LW'(pend), 3 - i);
                if (i < 3) chk("R5 no early evt", LW'(evt_valid), 0);
                if (i == 1) begin
                    chk("R7 mrsp valid", LW'(mrsp_valid), 1);
                    chk("R7 mrsp data", mrsp_data, md);
                end
            end
            exp_evt = (sh && ow) ? 2'd2 : sh ? 2'd1 : 2'd0;
            chk("R5 evt", LW'(evt_valid), 1); chk("R5 addr", LW'(evt_addr), LW'(a));
            chk("R4 kind", LW'(evt_kind), LW'(exp_evt));
            chk("R6 line", line, exp_line); chk("R6 dirty", LW'(dirty), LW'(exp_dirty));
            chk("R9 wb valid", LW'(wb_valid), LW'(kind == 3));
            if (kind == 3) chk("R9 wb data", wb_data, merge(exp_line, dma, off, len));
            step();
            chk("R5 single pulse", LW'(evt_valid), 0);
            release_slot();
            chk("R11 busy", LW'(busy), 0); chk("R11 pend", LW'(pend), 0);
        end

        // Exhaustive offset/length merge over memory-supplied lines
        for (int off = 0; off < NB; off++) begin
            for (int len = 0; len <= NB; len++) begin
                logic [LW-1:0] md = pattern(off * 11 + len);
                logic [LW-1:0] dma = ~pattern(len * 7 + off);
                alloc(16'h0ABC, 2'd3, 1'b0, off, len, dma);
                mem_valid = 1; mem_data = md; step(); mem_valid = 0;
                for (int i = 0; i < NC; i++) respond(3'd0, '0);
                chk("R9 merge", wb_data, merge(md, dma, off, len));
                release_slot();
            end
        end

        // R8 overrides
        alloc(16'h0101, 2'd0, 1'b1, 0, 0, '0);
        pset_valid = 1; pset_sel = 2'd0; step(); pset_valid = 0;
        chk("R8 set one", LW'(pend), 1); chk("R8 no evt", LW'(evt_valid), 0);
        respond(3'd1, '0);
        chk("R8 evt after one", LW'(evt_valid), 1); chk("R8 kind", LW'(evt_kind), 1);
        release_slot();

        alloc(16'h0202, 2'd1, 1'b1, 0, 0, '0);
        respond(3'd0, '0);
        pset_valid = 1; pset_sel = 2'd2; step(); pset_valid = 0;
        chk("R8 zero filtered", LW'(pend), 0); chk("R8 zero evt", LW'(evt_valid), 1);
        chk("R8 zero kind", LW'(evt_kind), 0);
        release_slot();

        alloc(16'h0303, 2'd1, 1'b0, 0, 0, '0);
        pset_valid = 1; pset_sel = 2'd2; step(); pset_valid = 0;
        chk("R8 zero unfiltered ignored", LW'(pend), NC);
        chk("R8 zero unfiltered no evt", LW'(evt_valid), 0);
        respond(3'd0, '0);
        pset_valid = 1; pset_sel = 2'd1; step(); pset_valid = 0;
        chk("R8 set all", LW'(pend), NC);
        pset_valid = 1; pset_sel = 2'd0;
        respond(3'd2, pattern(77));
        pset_valid = 0;
        chk("R8 override wins", LW'(pend), 1);
        chk("R8 data still taken", line, pattern(77)); chk("R8 dirty", LW'(dirty), 1);
        respond(3'd0, '0);
        chk("R8 owned evt", LW'(evt_valid), 1); chk("R4 owned", LW'(evt_kind), 2);
        release_slot();

        // R2 allocate while busy is ignored
        alloc(16'h1234, 2'd0, 1'b0, 0, 0, '0);
        respond(3'd0, '0);
        alloc(16'h4321, 2'd3, 1'b1, 2, 3, pattern(5));
        chk("R2 busy alloc pend", LW'(pend), NC - 1);
        chk("R2 busy alloc excl", LW'(mrsp_excl), 0);
        chk("R2 busy alloc acks", LW'(mrsp_acks), 1);
        for (int i = 0; i < NC - 1; i++) respond(3'd0, '0);
        chk("R2 evt addr kept", LW'(evt_addr), 16'h1234);
        chk("R2 no wb", LW'(wb_valid), 0);
        release_slot();

        // R10 error cases
        respond(3'd3, pattern(9));
        chk("R10 idle rsp err", LW'(err), 1);
        step();
        chk("R10 sticky", LW'(err), 1);
        do_reset();
        chk("R10 cleared by reset", LW'(err), 0);
        alloc(16'h0404, 2'd0, 1'b0, 0, 0, '0);
        for (int i = 0; i < NC; i++) respond(3'd0, '0);
        chk("R10 no err yet", LW'(err), 0);
        respond(3'd2, pattern(33));
        chk("R10 late rsp err", LW'(err), 1);
        chk("R10 line untouched", line, '0); chk("R10 dirty untouched", LW'(dirty), 0);
        chk("R10 pend stays", LW'(pend), 0); chk("R10 no evt", LW'(evt_valid), 0);
        release_slot();
        alloc(16'h0505, 2'd2, 1'b0, 0, 0, '0);
        chk("R11 realloc", LW'(busy), 1);
        release_slot();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule